// File: doc/BRIEF.md
# Scanline Interrupt Counter with Edge Qualifier

This block produces a raster-timed interrupt for a video subsystem. It watches address line 12 of the pattern fetch bus, once per clock. When that line rises after a long enough low period, the block treats the rise as one scanline tick. Each tick clocks an 8-bit down-counter. When the counter reaches zero while interrupts are enabled, a sticky pending flag is set and drives the IRQ output.

The CPU side reaches the block through four single-cycle write strobes, which the surrounding bus decode produces. One strobe stores a reload value. One asks for a reload on the next tick. One disables the interrupt and acknowledges it. One enables the interrupt. A parameter chooses between two versions of the zero-detect rule. One version fires whenever the counter is zero after a tick. The other fires only when the counter has just arrived at zero.

Top module: `scanline_irq`

## Requirements
- R1: After reset, the irq output is low. The counter, reload value, reload request, enable and pending flag are all zero.
- R2: A high sample of a12 counts as a tick only if the LOW_MIN samples just before it (default 4) were all low. A high sample after a shorter low run is ignored and leaves the counter unchanged.
- R3: Only the first high sample after a qualifying low run counts. Further consecutive high samples do not tick.
- R4: On a tick, the counter loads the reload value if it is zero or if a reload is requested. Otherwise it decreases by one.
- R5: With REV_A=0, a tick that leaves the counter at zero while enabled sets the pending flag. With a reload value of zero this repeats on every tick.
- R6: With REV_A=1, a tick sets the pending flag only if it leaves the counter at zero, interrupts are enabled, and before the tick the counter was nonzero or a reload was requested.
- R7: Every tick clears the reload request. The reload strobe only sets the request and does not change the counter by itself.
- R8: The latch strobe stores wdata as the reload value and does not change the counter.
- R9: The disable strobe clears both enable and pending. In the same cycle it takes priority over a firing tick and over the enable strobe.
- R10: The enable strobe sets enable. irq equals the pending flag and stays high until a disable strobe.
- R11: A tick uses the register state from before the clock edge. A latch strobe in the same cycle takes effect only from the next tick, and a reload strobe in the same cycle leaves the request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a12 | input | 1 | Video address bit 12, sampled every clock |
| wr_latch | input | 1 | Store wdata as the reload value |
| wr_reload | input | 1 | Request a reload on the next tick |
| wr_disable | input | 1 | Disable interrupts and clear pending |
| wr_enable | input | 1 | Enable interrupts |
| wdata | input | CNT_W | Write data for the latch strobe |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
The bench drives a12 with low runs of exactly three and exactly four samples, and with long high plateaus. A qualifier that is off by one, or that re-counts a held-high line, would then add or drop ticks and move the interrupt. A rev-B/C instance and a rev-A instance receive the same stimulus with a reload value of zero. Swapped zero-detect logic would show up as a missing repeat interrupt on one instance, or an extra one on the other. Strobes collide with ticks on purpose, so the wrong priority or use of post-write state changes the cycle in which irq rises or clears.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 4,
  parameter bit REV_A   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a12,
  input  logic             wr_latch,
  input  logic             wr_reload,
  input  logic             wr_disable,
  input  logic             wr_enable,
  input  logic [CNT_W-1:0] wdata,
  output logic             irq
);
  localparam int RUN_W = $clog2(LOW_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOW_MIN);

  logic [RUN_W-1:0] low_run;
  logic [CNT_W-1:0] cnt, latch_q, cnt_nxt;
  logic reload_q, en_q, pend_q, hit, fire;

  assign hit     = a12 && (low_run == RUN_FULL);
  assign cnt_nxt = (cnt == '0 || reload_q) ? latch_q : cnt - CNT_W'(1);
  assign irq     = pend_q;

  generate
    if (REV_A) begin : gen_rev_a
      assign fire = hit && en_q && (cnt_nxt == '0) && (cnt != '0 || reload_q);
    end else begin : gen_rev_bc
      assign fire = hit && en_q && (cnt_nxt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (a12) low_run <= '0;
    else if (low_run != RUN_FULL) low_run <= low_run + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      latch_q  <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (hit) cnt <= cnt_nxt;
      if (wr_latch) latch_q <= wdata;
      if (wr_reload) reload_q <= 1'b1;
      else if (hit) reload_q <= 1'b0;
      if (wr_disable) en_q <= 1'b0;
      else if (wr_enable) en_q <= 1'b1;
      if (wr_disable) pend_q <= 1'b0;
      else if (fire) pend_q <= 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> !irq && cnt == '0 && !en_q);
  p_short_low_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a12 && low_run != RUN_FULL |=> $stable(cnt));
  p_no_tick_when_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a12 && $past(a12) && rst_n |=> $stable(cnt));
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cnt != '0 && !reload_q |=> cnt == $past(cnt) - CNT_W'(1));
  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q));
  p_reload_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr_reload |=> !reload_q);
  p_latch_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> latch_q == $past(wdata));
  p_disable_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> !irq && !en_q);
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_disable |=> irq);
endmodule

// File: tb/test_scanline_irq.sv
module test_scanline_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a12 = 1'b0, wl = 1'b0, wr = 1'b0, wd = 1'b0, we = 1'b0;
  logic [7:0] data = '0;
  logic irq_bc, irq_a;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scanline_irq #(.REV_A(1'b0)) i_scanline_irq (.clk(clk), .rst_n(rst_n), .a12(a12),
    .wr_latch(wl), .wr_reload(wr), .wr_disable(wd), .wr_enable(we), .wdata(data), .irq(irq_bc));
  scanline_irq #(.REV_A(1'b1)) i_scanline_irq_a (.clk(clk), .rst_n(rst_n), .a12(a12),
    .wr_latch(wl), .wr_reload(wr), .wr_disable(wd), .wr_enable(we), .wdata(data), .irq(irq_a));

  // model, index 0 = rev B/C, 1 = rev A
  int m_run;
  logic [7:0] m_cnt[2], m_lat[2];
  logic m_rel[2], m_en[2], m_pend[2];

  function automatic logic [7:0] next_count(logic [7:0] c, logic rel, logic [7:0] lat);
    return (c == 0 || rel) ? lat : c - 8'd1;
  endfunction

  task automatic model_reset();
    m_run = 0;
    for (int r = 0; r < 2; r++) begin
      m_cnt[r] = 0; m_lat[r] = 0; m_rel[r] = 0; m_en[r] = 0; m_pend[r] = 0;
    end
  endtask

  task automatic model_step();
    logic tick, fire;
    logic [7:0] nx;
    tick = a12 && m_run >= 4;
    m_run = a12 ? 0 : m_run + 1;
    for (int r = 0; r < 2; r++) begin
      fire = 0;
      if (tick) begin
        nx = next_count(m_cnt[r], m_rel[r], m_lat[r]);
        fire = (nx == 0) && m_en[r] && (r == 0 || m_cnt[r] != 0 || m_rel[r]);
        m_cnt[r] = nx;
        m_rel[r] = 0;
      end
      if (wl) m_lat[r] = data;
      if (wr) m_rel[r] = 1;
      if (wd) begin m_pend[r] = 0; m_en[r] = 0; end
      else begin
        if (fire) m_pend[r] = 1;
        if (we) m_en[r] = 1;
      end
    end
  endtask

  task automatic check(string tag);
    n_chk += 2;
    if (irq_bc !== m_pend[0]) begin
      n_fail++;
      $display("FAIL %s revBC irq=%b expected %b at %0t", tag, irq_bc, m_pend[0], $time);
    end
    if (irq_a !== m_pend[1]) begin
      n_fail++;
      $display("FAIL %s revA irq=%b expected %b at %0t", tag, irq_a, m_pend[1], $time);
    end
  endtask

  task automatic cyc(logic i_a12, logic i_wl, logic i_wr, logic i_wd, logic i_we,
                     logic [7:0] d, string tag);
    a12 = i_a12; wl = i_wl; wr = i_wr; wd = i_wd; we = i_we; data = d;
    model_step();
    @(posedge clk); @(negedge clk);
    check(tag);
  endtask

  task automatic low_high(int lows, string tag);
    for (int i = 0; i < lows; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    cyc(1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; model_reset();
    check("R1 reset");
    // latch 2, reload, enable
    cyc(0, 1, 0, 0, 0, 8'd2, "R8");
    cyc(0, 0, 1, 0, 1, 0, "R7");
    low_high(4, "R4 load");          // cnt=2
    low_high(3, "R2 short low");     // ignored
    low_high(4, "R4 dec");           // cnt=1
    cyc(1, 0, 0, 0, 0, 0, "R3 held high");
    cyc(1, 0, 0, 0, 0, 0, "R3 held high");
    low_high(5, "R5 R6 reach zero"); // cnt=0, both fire
    low_high(4, "R10 sticky");       // reload from 2, stays high
    cyc(0, 0, 0, 1, 1, 0, "R9 disable beats enable");
    // latch 0: B/C repeats, A does not
    cyc(0, 1, 1, 0, 1, 8'd0, "R8 latch zero");
    low_high(4, "R6 reload to zero");
    cyc(0, 0, 0, 1, 0, 0, "R9 ack");
    cyc(0, 0, 0, 0, 1, 0, "R10 enable");
    low_high(4, "R5 repeat zero");
    low_high(4, "R6 no repeat");
    // collisions: tick with disable, latch and reload strobes
    cyc(0, 0, 0, 1, 0, 0, "R9");
    cyc(0, 1, 0, 0, 1, 8'd1, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R11");
    cyc(1, 1, 1, 1, 0, 8'd3, "R11 R9 collide");
    cyc(0, 0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R11");
    cyc(1, 0, 0, 0, 0, 0, "R11 R7 reload kept");
    // random phase
    void'($urandom(32'h5CA7_1E12));
    for (int k = 0; k < 3000; k++) begin
      int lows = 1 + $urandom_range(0, 6);
      int highs = 1 + $urandom_range(0, 2);
      for (int j = 0; j < lows + highs; j++) begin
        cyc(j >= lows, $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
            $urandom_range(0, 24) == 0, $urandom_range(0, 9) == 0,
            8'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 5)), "R5 R6 random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule